// File: doc/BRIEF.md
# Fixed-Point 8-Point Row Inverse DCT

This block takes one row of eight signed 16-bit transform coefficients and returns eight signed 16-bit spatial samples. It computes a one-dimensional 8-point inverse DCT with integer arithmetic, as the first pass of a separable 2-D inverse transform.

The row arrives on a valid/ready handshake and the result leaves on a valid/ready output. Inside, the even-indexed coefficients form four even sums (A0..A3) and the odd-indexed coefficients form four odd sums (B0..B3). A butterfly combines them, adds a rounding bias, shifts right by 11 and keeps the low 16 bits.

Two kinds of row take a shortcut. A row with only the DC term skips every multiplier and finishes one cycle sooner. A row whose upper four coefficients are zero gates those products off.

Top module: `idct8_row_core`

## Requirements
- R1: While reset is high and in the cycle after it falls, `out_valid` is 0. After reset, `in_ready` is 1 while the output is empty.
- R2: Coefficient rk sits in `in_coef[16k+15:16k]` and output yk in `out_data[16k+15:16k]`. Both are two's complement. Even sums use the weights C2=21407, C4=16383, C6=8867:
  - A0 = C4·r0 + C2·r2 + C4·r4 + C6·r6
  - A1 = C4·r0 + C6·r2 − C4·r4 − C2·r6
  - A2 = C4·r0 − C6·r2 − C4·r4 + C2·r6
  - A3 = C4·r0 − C2·r2 + C4·r4 − C6·r6
- R3: Odd sums use the weights C1=22725, C3=19266, C5=12873, C7=4520:
  - B0 = C1·r1 + C3·r3 + C5·r5 + C7·r7
  - B1 = C3·r1 − C7·r3 − C1·r5 − C5·r7
  - B2 = C5·r1 − C1·r3 + C7·r5 + C3·r7
  - B3 = C7·r1 − C5·r3 + C3·r5 − C1·r7

  The outputs pair them as y0/y7 = A0±B0, y1/y6 = A1±B1, y2/y5 = A2±B2, y3/y4 = A3±B3.
- R4: Each output is (sum + 1024) arithmetically shifted right by 11, then cut to its low 16 bits with no saturation. Sums are held exactly.
- R5: A row with r1..r7 all zero gives r0·8, truncated to 16 bits, on every output. It appears one cycle after the accepting edge.
- R6: A row with r4..r7 zero and some of r1..r3 non-zero gives the R2–R4 result two cycles after the accepting edge.
- R7: Any other row gives the R2–R4 result two cycles after the accepting edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds and `in_ready` stays low, so no new row is taken. Exactly one row is accepted per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block can take a row this cycle |
| in_coef | input | 128 | Eight signed 16-bit coefficients, r0 in the low lane |
| out_valid | output | 1 | Result row present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Eight signed 16-bit results, y0 in the low lane |

## Verification
- **DC row with r0=2000.** The correct answer is 16000. A design that sends this row through the multipliers yields 15999, because C4 sits just below 2^14.
- **DC row with r0=5000.** The correct answer wraps to −25536. A design that saturates, or that misreads which lanes must be zero, gives a different value.
- **Impulse rows, one per odd and one per upper-even coefficient.** These expose a swapped weight or a swapped butterfly pairing. Half rows expose a design that gates the wrong lanes.
- **Latency and back-pressure.** Each row's latency is counted. A stalled output is held while a new row waits at the input, which catches a design that overwrites a pending result or accepts a row early.

// File: rtl/idct8_pkg.sv
package idct8_pkg;
    localparam int COEF_W    = 16;
    localparam int LANES     = 8;
    localparam int HALF      = LANES / 2;
    localparam int ACC_W     = 36;
    localparam int ROW_SHIFT = 11;
    localparam int ROW_W     = COEF_W * LANES;

    // cosine weights scaled by sqrt(2)*2^14
    localparam int C1 = 22725;
    localparam int C2 = 21407;
    localparam int C3 = 19266;
    localparam int C4 = 16383;
    localparam int C5 = 12873;
    localparam int C6 = 8867;
    localparam int C7 = 4520;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef coef_t [LANES-1:0]        row_t;
    typedef acc_t  [HALF-1:0]         quad_t;

    typedef enum logic [1:0] {
        KIND_FULL,
        KIND_LOWHALF,
        KIND_DCONLY
    } row_kind_t;

    localparam acc_t ROUND_BIAS = acc_t'(1) <<< (ROW_SHIFT - 1);

    function automatic acc_t wmul(input coef_t c, input int w);
        acc_t a;
        acc_t b;
        a = acc_t'(c);
        b = acc_t'(w);
        return a * b;
    endfunction
endpackage

// File: rtl/idct8_classify.sv
module idct8_classify
    import idct8_pkg::*;
(
    input  row_t      row,
    output row_kind_t kind
);
    logic upper_zero;
    logic low_odd_zero;

    always_comb begin
        upper_zero   = 1'b1;
        low_odd_zero = 1'b1;
        for (int k = HALF; k < LANES; k++) begin
            if (row[k] != '0) upper_zero = 1'b0;
        end
        for (int k = 1; k < HALF; k++) begin
            if (row[k] != '0) low_odd_zero = 1'b0;
        end
        if (upper_zero && low_odd_zero) kind = KIND_DCONLY;
        else if (upper_zero)            kind = KIND_LOWHALF;
        else                            kind = KIND_FULL;
    end
endmodule

// File: rtl/idct8_even.sv
module idct8_even
    import idct8_pkg::*;
(
    input  row_t  row,
    input  logic  low_only,
    output quad_t a
);
    coef_t r4g, r6g;
    acc_t  base, p4, s26, d26;

    always_comb begin
        r4g  = low_only ? '0 : row[4];
        r6g  = low_only ? '0 : row[6];
        base = wmul(row[0], C4) + ROUND_BIAS;
        p4   = wmul(r4g, C4);
        s26  = wmul(row[2], C2) + wmul(r6g, C6);
        d26  = wmul(row[2], C6) - wmul(r6g, C2);
        a[0] = (base + p4) + s26;
        a[3] = (base + p4) - s26;
        a[1] = (base - p4) + d26;
        a[2] = (base - p4) - d26;
    end
endmodule

// File: rtl/idct8_odd.sv
module idct8_odd
    import idct8_pkg::*;
(
    input  row_t  row,
    input  logic  low_only,
    output quad_t b
);
    coef_t r5g, r7g;

    always_comb begin
        r5g  = low_only ? '0 : row[5];
        r7g  = low_only ? '0 : row[7];
        b[0] = wmul(row[1], C1) + wmul(row[3], C3) + wmul(r5g, C5) + wmul(r7g, C7);
        b[1] = wmul(row[1], C3) - wmul(row[3], C7) - wmul(r5g, C1) - wmul(r7g, C5);
        b[2] = wmul(row[1], C5) - wmul(row[3], C1) + wmul(r5g, C7) + wmul(r7g, C3);
        b[3] = wmul(row[1], C7) - wmul(row[3], C5) + wmul(r5g, C3) - wmul(r7g, C1);
    end
endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly
    import idct8_pkg::*;
(
    input  quad_t a,
    input  quad_t b,
    output row_t  y
);
    for (genvar i = 0; i < HALF; i++) begin : g_pair
        acc_t sum_s, dif_s;
        assign sum_s          = (a[i] + b[i]) >>> ROW_SHIFT;
        assign dif_s          = (a[i] - b[i]) >>> ROW_SHIFT;
        assign y[i]           = sum_s[COEF_W-1:0];
        assign y[LANES-1-i]   = dif_s[COEF_W-1:0];
    end
endmodule

// File: rtl/idct8_row_core.sv
module idct8_row_core
    import idct8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ROW_W-1:0] in_coef,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_data
);
    row_t      in_row;
    row_kind_t in_kind;
    row_t      stage_row;
    logic      stage_low;
    logic      busy;
    quad_t     even_q, odd_q;
    row_t      bfly_row;
    row_t      dc_row;
    row_t      res_row;
    logic      out_free;
    logic      accept;

    assign in_row   = row_t'(in_coef);
    assign out_free = !out_valid || out_ready;
    assign in_ready = !busy && out_free;
    assign accept   = in_valid && in_ready;
    assign out_data = ROW_W'(res_row);

    idct8_classify u_cls (.row(in_row), .kind(in_kind));
    idct8_even     u_even (.row(stage_row), .low_only(stage_low), .a(even_q));
    idct8_odd      u_odd  (.row(stage_row), .low_only(stage_low), .b(odd_q));
    idct8_butterfly u_bfly (.a(even_q), .b(odd_q), .y(bfly_row));

    for (genvar k = 0; k < LANES; k++) begin : g_dc
        assign dc_row[k] = in_row[0] <<< 3;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            out_valid <= 1'b0;
            stage_low <= 1'b0;
            stage_row <= '0;
            res_row   <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (busy && out_free) begin
                res_row   <= bfly_row;
                out_valid <= 1'b1;
                busy      <= 1'b0;
            end
            if (accept) begin
                if (in_kind == KIND_DCONLY) begin
                    res_row   <= dc_row;
                    out_valid <= 1'b1;
                end else begin
                    stage_row <= in_row;
                    stage_low <= (in_kind == KIND_LOWHALF);
                    busy      <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/idct8_row_chk.sv
module idct8_row_chk
    import idct8_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [ROW_W-1:0] in_coef,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_data
);
    logic dc_in;
    logic [ROW_W-1:0] dc_expect;
    assign dc_in = (in_coef[ROW_W-1:COEF_W] == '0);
    for (genvar k = 0; k < LANES; k++) begin : g_exp
        assign dc_expect[k*COEF_W +: COEF_W] = in_coef[COEF_W-1:0] << 3;
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_dc_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && dc_in) |=> (out_valid && out_data == $past(dc_expect)));

    p_full_two_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !dc_in) |=> !out_valid);

    p_hold_data_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_no_take_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind idct8_row_core idct8_row_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/sim_idct8_row_core.sv
module sim_idct8_row_core;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_coef = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    idct8_row_core u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    function automatic logic [127:0] mk(input int a0, a1, a2, a3, a4, a5, a6, a7);
        logic [127:0] r;
        int v[8];
        v = '{a0, a1, a2, a3, a4, a5, a6, a7};
        for (int i = 0; i < 8; i++) r[16*i +: 16] = v[i][15:0];
        return r;
    endfunction

    function automatic logic [127:0] ref_row(input logic [127:0] row);
        longint r[8];
        longint a[4];
        longint b[4];
        longint y[8];
        logic [63:0] t;
        logic [127:0] o;
        bit dc = 1;
        for (int i = 0; i < 8; i++) begin
            r[i] = longint'($signed(row[16*i +: 16]));
            if (i > 0 && r[i] != 0) dc = 0;
        end
        if (dc) begin
            for (int i = 0; i < 8; i++) begin
                t = 64'(r[0] * 8);
                o[16*i +: 16] = t[15:0];
            end
            return o;
        end
        a[0] = 16383*r[0] + 21407*r[2] + 16383*r[4] + 8867*r[6] + 1024;
        a[1] = 16383*r[0] + 8867*r[2] - 16383*r[4] - 21407*r[6] + 1024;
        a[2] = 16383*r[0] - 8867*r[2] - 16383*r[4] + 21407*r[6] + 1024;
        a[3] = 16383*r[0] - 21407*r[2] + 16383*r[4] - 8867*r[6] + 1024;
        b[0] = 22725*r[1] + 19266*r[3] + 12873*r[5] + 4520*r[7];
        b[1] = 19266*r[1] - 4520*r[3] - 22725*r[5] - 12873*r[7];
        b[2] = 12873*r[1] - 22725*r[3] + 4520*r[5] + 19266*r[7];
        b[3] = 4520*r[1] - 12873*r[3] + 19266*r[5] - 22725*r[7];
        for (int i = 0; i < 4; i++) begin
            y[i]   = (a[i] + b[i]) >>> 11;
            y[7-i] = (a[i] - b[i]) >>> 11;
        end
        for (int i = 0; i < 8; i++) begin
            t = 64'(y[i]);
            o[16*i +: 16] = t[15:0];
        end
        return o;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // send one row, measure latency from the accepting edge, check result, consume it
    task automatic run_row(input logic [127:0] row, input int exp_lat, input string req);
        int lat;
        @(negedge clk);
        in_coef = row;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, req, "latency", 128'(lat), 128'(exp_lat));
        check(out_data == ref_row(row), req, "data", out_data, ref_row(row));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset;
        // R1: output empty, input open after reset
        check(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'(0));
        check(in_ready == 1'b1, "R1", "in_ready after reset", 128'(in_ready), 128'(1));
    endtask

    task automatic t_dc_rows;
        run_row(mk(2000, 0, 0, 0, 0, 0, 0, 0), 1, "R5");   // 16000, not 15999
        run_row(mk(-3, 0, 0, 0, 0, 0, 0, 0), 1, "R5");
        run_row(mk(5000, 0, 0, 0, 0, 0, 0, 0), 1, "R5");   // wraps to -25536
    endtask

    task automatic t_low_half;
        run_row(mk(100, 50, 0, 0, 0, 0, 0, 0), 2, "R6");
        run_row(mk(-700, 0, 333, -1200, 0, 0, 0, 0), 2, "R6");
        run_row(mk(0, 0, 0, 1, 0, 0, 0, 0), 2, "R6");
    endtask

    task automatic t_impulses;
        // R2 R3: a single non-zero lane exposes a wrong weight or pairing
        run_row(mk(0, 0, 0, 0, 1000, 0, 0, 0), 2, "R2");
        run_row(mk(0, 0, 0, 0, 0, 0, -900, 0), 2, "R2");
        run_row(mk(0, 0, 0, 0, 0, 1000, 0, 0), 2, "R3");
        run_row(mk(0, 0, 0, 0, 0, 0, 0, 777), 2, "R3");
        run_row(mk(0, 2000, 0, 0, 0, 0, 0, 0), 2, "R3");
    endtask

    task automatic t_full_rows;
        run_row(mk(120, -45, 30, 7, -12, 5, -3, 1), 2, "R7");
        run_row(mk(-1, 1, -1, 1, -1, 1, -1, 1), 2, "R4");
        run_row(mk(32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767), 2, "R4");
        run_row(mk(-32768, 32767, -32768, 32767, -32768, 32767, -32768, 32767), 2, "R4");
    endtask

    task automatic t_hold;
        logic [127:0] r_a, r_b, held;
        int lat;
        r_a = mk(10, 20, 30, 40, 50, 60, 70, 80);
        r_b = mk(400, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        in_coef = r_a;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_coef = r_b;              // second row waits at the input
        @(negedge clk);
        check(out_valid == 1'b1, "R8", "first result present", 128'(out_valid), 128'(1));
        held = out_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R8", "in_ready while stalled", 128'(in_ready), 128'(0));
            check(out_data == held, "R8", "held data", out_data, held);
        end
        check(held == ref_row(r_a), "R8", "first result value", held, ref_row(r_a));
        out_ready = 1'b1;           // consume; second row is taken at this edge
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(out_data == ref_row(r_b), "R8", "second result", out_data, ref_row(r_b));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(out_valid == 1'b0, "R8", "single result per row", 128'(out_valid), 128'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dc_rows();
        t_low_half();
        t_impulses();
        t_full_rows();
        t_hold();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule